// File: doc/BRIEF.md
# Minute Timer and Low-Battery Status Generator

This block decides when a host must be sent a status update, and which status bits that update carries. It has two sources. The first is a minute timer that counts one-second timebase ticks while its enable is set and raises a minute-timeout indication once every sixty ticks. The second is a battery monitor. It watches an external low-battery pin through a two-stage synchronizer and reports each change of the pin level after the device has been turned on. A programmable polarity bit selects which pin level means low battery.

The timer runs a two-state machine. In `TMR_IDLE` the count holds. The transition *arm* (enable seen high) moves to `TMR_RUN` and zeroes the count. The transition *disarm* (enable seen low) moves back to `TMR_IDLE`. The battery monitor also runs two states. `BAT_OFF` ignores the pin. The transition *power-up* (turn-on command) enters `BAT_ON` and preloads the battery bit with the inverse of the polarity. In `BAT_ON`, a turn-on command *reloads* that preset, and any difference between the synchronized pin and the stored bit causes a *report*. A merge stage turns the two event sources into one registered strobe.

Top module: `minute_lobat_status`

## Requirements
- R1: After reset, `status_req`, `mt_flag` and `lb_flag` are 0, the timer is idle and the battery monitor is off.
- R2: While `mt_en` is high, every 60th `sec_tick` (the count wraps from 59 to 0) produces `status_req`=1 with `mt_flag`=1 in the cycle after that tick is sampled.
- R3: While `mt_en` is low, ticks produce no timeout and the count holds.
- R4: A 0-to-1 change of `mt_en` restarts the count from zero, so the next timeout needs a full 60 ticks.
- R5: A cycle with `mt_clr` high zeroes the count, so the next timeout needs a full 60 ticks after it.
- R6: Before the first `dev_on`, changes on `lobat_pin` cause no request, and `lb_flag` keeps its value.
- R7: The cycle after `dev_on` is sampled, `lb_flag` equals the inverse of `lb_pol` and no request is made for that edge.
- R8: After turn-on, the first battery request comes when the synchronized pin reaches the low-battery level (pin equal to `lb_pol`: 1 means active-high, 0 means active-low). `lb_flag` then shows that pin level. If the pin is already at that level when the device turns on, the request follows in the next cycle.
- R9: Each later change of the pin level gives exactly one request, 3 clock edges after the pin changes (2 synchronizer stages plus 1 output register), and `lb_flag` follows the pin level.
- R10: A timeout and a battery change that fall in the same cycle give one single-cycle request with `mt_flag`=1 and the new `lb_flag`.
- R11: `mt_flag` is high only together with `status_req`, and each request lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second of timebase |
| mt_en | input | 1 | Minute timer enable |
| mt_clr | input | 1 | Minute count clear command |
| lb_pol | input | 1 | Battery pin polarity, 1 = high level means low battery |
| dev_on | input | 1 | Turn-on command pulse |
| lobat_pin | input | 1 | Asynchronous low-battery pin |
| status_req | output | 1 | One-cycle status send strobe |
| mt_flag | output | 1 | Minute-timeout bit, valid with the strobe |
| lb_flag | output | 1 | Reported battery pin level |

## Verification
The minute timeout and a battery pin change can both land on the same clock edge. The bench provokes this by stopping the count at 59 and changing the pin two edges before the final tick, so that the synchronizer output and the timeout tick are sampled together. It then requires a single strobe that carries both the timeout bit and the new battery level. It also requires the strobe to be low again in the next cycle, which shows that no second request was made.

// File: rtl/mls_pkg.sv
package mls_pkg;
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;

    typedef enum logic {
        BAT_OFF = 1'b0,
        BAT_ON  = 1'b1
    } bat_state_t;
endpackage

// File: rtl/mls_sync.sv
module mls_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/mls_minute_timer.sv
module mls_minute_timer
    import mls_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic mt_en,
    input  logic mt_clr,
    output logic mt_evt
);
    localparam int CW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MIN - 1);

    tmr_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        mt_evt  = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (mt_en) begin
                    state_d = TMR_RUN;
                    cnt_d   = '0;
                end else if (mt_clr) begin
                    cnt_d = '0;
                end
            end
            TMR_RUN: begin
                if (!mt_en) begin
                    state_d = TMR_IDLE;
                    if (mt_clr) cnt_d = '0;
                end else if (mt_clr) begin
                    cnt_d = '0;
                end else if (sec_tick) begin
                    if (cnt_q == LAST) begin
                        cnt_d  = '0;
                        mt_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mt_en && !mt_clr) |=> $stable(cnt_q));
    assert_restart_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_IDLE && mt_en) |=> (cnt_q == '0));
    assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mt_clr |=> (cnt_q == '0));
endmodule

// File: rtl/mls_lobat_monitor.sv
module mls_lobat_monitor
    import mls_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lb_pol,
    input  logic dev_on,
    input  logic lobat_pin,
    output logic lb_evt,
    output logic lb_level
);
    bat_state_t state_q, state_d;
    logic pin_s;
    logic lvl_q, lvl_d;

    mls_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (lobat_pin),
        .d_out (pin_s)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BAT_OFF;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        lb_evt  = 1'b0;
        unique case (state_q)
            BAT_OFF: begin
                if (dev_on) begin
                    state_d = BAT_ON;
                    lvl_d   = ~lb_pol;
                end
            end
            BAT_ON: begin
                if (dev_on) begin
                    lvl_d = ~lb_pol;
                end else if (pin_s != lvl_q) begin
                    lvl_d  = pin_s;
                    lb_evt = 1'b1;
                end
            end
            default: state_d = BAT_OFF;
        endcase
    end

    assign lb_level = lvl_q;

    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BAT_OFF && !dev_on) |=> $stable(lvl_q));
    assert_preset_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_on |=> (lvl_q == ~$past(lb_pol)));
    assert_level_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lb_evt |=> (lvl_q == $past(pin_s)));
endmodule

// File: rtl/mls_status_merge.sv
module mls_status_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic mt_evt,
    input  logic lb_evt,
    output logic status_req,
    output logic mt_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_req <= 1'b0;
            mt_flag    <= 1'b0;
        end else begin
            status_req <= mt_evt | lb_evt;
            mt_flag    <= mt_evt;
        end
    end

    assert_flag_with_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mt_flag |-> status_req);
    assert_merge_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_evt && lb_evt) |=> (status_req && mt_flag));
endmodule

// File: rtl/minute_lobat_status.sv
module minute_lobat_status #(
    parameter int TICKS_PER_MIN = 60,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic mt_en,
    input  logic mt_clr,
    input  logic lb_pol,
    input  logic dev_on,
    input  logic lobat_pin,
    output logic status_req,
    output logic mt_flag,
    output logic lb_flag
);
    logic mt_evt;
    logic lb_evt;

    mls_minute_timer #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .mt_en    (mt_en),
        .mt_clr   (mt_clr),
        .mt_evt   (mt_evt)
    );

    mls_lobat_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_bat (
        .clk       (clk),
        .rst_n     (rst_n),
        .lb_pol    (lb_pol),
        .dev_on    (dev_on),
        .lobat_pin (lobat_pin),
        .lb_evt    (lb_evt),
        .lb_level  (lb_flag)
    );

    mls_status_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .mt_evt     (mt_evt),
        .lb_evt     (lb_evt),
        .status_req (status_req),
        .mt_flag    (mt_flag)
    );

    assert_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_req && !mt_flag) |=> !(status_req && !mt_flag && $stable(lb_flag)));
endmodule

// File: tb/test_minute_lobat_status.sv
module test_minute_lobat_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0, mt_en = 1'b0, mt_clr = 1'b0;
    logic lb_pol = 1'b0, dev_on = 1'b0, lobat_pin = 1'b0;
    logic status_req, mt_flag, lb_flag;
    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    minute_lobat_status i_minute_lobat_status (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .mt_en(mt_en),
        .mt_clr(mt_clr), .lb_pol(lb_pol), .dev_on(dev_on),
        .lobat_pin(lobat_pin), .status_req(status_req),
        .mt_flag(mt_flag), .lb_flag(lb_flag)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic ticks_quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(req, "no request before timeout", status_req, 1'b0);
        end
    endtask

    task automatic t_reset();
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", "status_req", status_req, 1'b0);
        chk("R1", "mt_flag", mt_flag, 1'b0);
        chk("R1", "lb_flag", lb_flag, 1'b0);
    endtask

    task automatic t_bat_off();
        lobat_pin = 1'b1;
        cyc(4);
        chk("R6", "request while off", status_req, 1'b0);
        chk("R6", "lb_flag while off", lb_flag, 1'b0);
        lobat_pin = 1'b0;
        cyc(4);
        chk("R6", "request while off", status_req, 1'b0);
    endtask

    task automatic t_bat_pol0();
        lb_pol = 1'b0;
        lobat_pin = 1'b1;
        cyc(4);
        dev_on = 1'b1;
        cyc(1);
        dev_on = 1'b0;
        chk("R7", "lb_flag preset", lb_flag, 1'b1);
        chk("R7", "no request on turn-on", status_req, 1'b0);
        cyc(3);
        chk("R7", "good battery stays quiet", status_req, 1'b0);
        lobat_pin = 1'b0;
        cyc(2);
        chk("R9", "not before sync latency", status_req, 1'b0);
        cyc(1);
        chk("R8", "first low report", status_req, 1'b1);
        chk("R8", "lb_flag low level", lb_flag, 1'b0);
        chk("R8", "mt_flag clear", mt_flag, 1'b0);
        cyc(1);
        chk("R9", "single cycle report", status_req, 1'b0);
        lobat_pin = 1'b1;
        cyc(3);
        chk("R9", "recovery report", status_req, 1'b1);
        chk("R9", "lb_flag recovered", lb_flag, 1'b1);
        cyc(1);
        chk("R9", "single cycle report", status_req, 1'b0);
    endtask

    task automatic t_bat_pol1();
        lb_pol = 1'b1;
        dev_on = 1'b1;
        cyc(1);
        dev_on = 1'b0;
        chk("R7", "lb_flag preset pol1", lb_flag, 1'b0);
        chk("R7", "no request on turn-on", status_req, 1'b0);
        cyc(1);
        chk("R8", "already low reports at once", status_req, 1'b1);
        chk("R8", "lb_flag high level", lb_flag, 1'b1);
        lobat_pin = 1'b0;
        cyc(3);
        chk("R9", "change report pol1", status_req, 1'b1);
        chk("R9", "lb_flag pol1", lb_flag, 1'b0);
        cyc(1);
        chk("R9", "single cycle", status_req, 1'b0);
    endtask

    task automatic t_timer_basic();
        mt_en = 1'b1;
        cyc(1);
        ticks_quiet(59, "R2");
        tick();
        chk("R2", "timeout request", status_req, 1'b1);
        chk("R2", "timeout flag", mt_flag, 1'b1);
        cyc(1);
        chk("R11", "request one cycle", status_req, 1'b0);
        chk("R11", "flag one cycle", mt_flag, 1'b0);
        ticks_quiet(59, "R2");
        tick();
        chk("R2", "second minute", mt_flag, 1'b1);
    endtask

    task automatic t_timer_hold();
        ticks_quiet(30, "R3");
        mt_en = 1'b0;
        cyc(1);
        ticks_quiet(100, "R3");
        mt_en = 1'b1;
        cyc(1);
        ticks_quiet(59, "R4");
        tick();
        chk("R4", "timeout after restart", status_req, 1'b1);
        chk("R4", "timeout flag after restart", mt_flag, 1'b1);
    endtask

    task automatic t_timer_clear();
        ticks_quiet(40, "R5");
        mt_clr = 1'b1;
        cyc(1);
        mt_clr = 1'b0;
        ticks_quiet(59, "R5");
        tick();
        chk("R5", "timeout after clear", status_req, 1'b1);
        chk("R5", "flag after clear", mt_flag, 1'b1);
    endtask

    task automatic t_merge();
        ticks_quiet(59, "R10");
        lobat_pin = 1'b1;
        cyc(2);
        tick();
        chk("R10", "merged request", status_req, 1'b1);
        chk("R10", "merged mt_flag", mt_flag, 1'b1);
        chk("R10", "merged lb_flag", lb_flag, 1'b1);
        cyc(1);
        chk("R10", "no second request", status_req, 1'b0);
        chk("R11", "flag dropped", mt_flag, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_bat_off();
        t_bat_pol0();
        t_bat_pol1();
        t_timer_basic();
        t_timer_hold();
        t_timer_clear();
        t_merge();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule